// File: doc/BRIEF.md
# Gated Binary Seconds Counter

This block keeps elapsed time as a 32-bit binary count of seconds. It runs in a fast system clock domain. A 32.768 kHz clock-enable pulse feeds a prescaler, and each time the prescaler completes a full cycle of advancing pulses, the seconds count steps once. Software turns the seconds value into dates and times of day.

The count appears as four byte-wide registers, and a control register holds a halt bit. A write port loads any single byte. A read port returns one byte per request, one cycle after the request. Reading the lowest byte captures all four bytes into a shadow copy, so that a multi-byte read cannot be torn by a tick that lands partway through it.

A backup-mode flag from the power supervisor changes what the halt bit does:
- On main power, halt stops only the count. The prescaler keeps running.
- In backup mode, halt also freezes the prescaler. This models the oscillator being stopped.

Top module: `secs_counter`

## Requirements
- R1: The count increases by exactly one after every `PRESCALE_DIV` clock cycles in which `tick_en` is high and the prescaler is allowed to run, and it does not change between those steps.
- R2: The count bytes sit at addresses 0 (bits 7:0), 1 (bits 15:8), 2 (bits 23:16) and 3 (bits 31:24). `rd_data` carries the addressed byte on the cycle after `rd_en`.
- R3: A read of address 0 returns the live low byte and copies the whole count into a shadow. Reads of addresses 1 to 3 return shadow bytes, which ticks do not change.
- R4: A write to address 0 to 3 replaces only that byte and restarts the prescaler, so the next step comes a full `PRESCALE_DIV` advancing pulses later. A write takes priority over a step that falls in the same cycle.
- R5: Address 4 is the control register, with bit 7 as halt and bits 6:0 always reading 0. On main power with halt set, the count holds while the prescaler keeps advancing.
- R6: In backup mode with halt set, both the prescaler and the count freeze. After halt clears, the prescaler resumes from the phase it held.
- R7: In backup mode with halt clear, counting goes on exactly as on main power.
- R8: The count wraps from FFFFFFFFh to 00000000h.
- R9: After reset, the count, the shadow and the prescaler are 0 and halt is 0, so counting starts at once.
- R10: Addresses 5 to 7 read as 0, and writes to them change neither the count nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 32.768 kHz clock-enable pulse |
| on_battery | input | 1 | High while the supply is in backup mode |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |

## Verification
The bench tries three tick patterns:
- A continuous `tick_en` checks the step rate.
- A sparse one-in-three `tick_en` shows that only enabled cycles advance the prescaler.
- Stretches with `tick_en` stopped show that the count does not drift on its own.

The halt bit is exercised both on main power and in backup mode. After halt is released, the time to the next step separates a prescaler that kept running from one that was frozen.

A read of address 0 is placed in the very cycle of a carry into byte 1, which shows whether the upper bytes come from the shadow copy. Byte writes placed partway through a second show whether the prescaler restarts.

// File: rtl/secs_pkg.sv
package secs_pkg;
  localparam int unsigned CNT_W      = 32;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned BYTE_LANES = CNT_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;
  localparam int unsigned HALT_BIT   = 7;

  // Replace one byte lane of a count word.
  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] w,
                                                 input logic [1:0] idx,
                                                 input logic [7:0] b);
    logic [CNT_W-1:0] r;
    r = w;
    r[idx*8 +: 8] = b;
    return r;
  endfunction

  // Pick one byte lane of a count word.
  function automatic logic [7:0] get_byte(input logic [CNT_W-1:0] w,
                                          input logic [1:0] idx);
    return w[idx*8 +: 8];
  endfunction

  // Count advance with natural modulo-2^32 wrap.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] w);
    return w + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic restart,
  output logic sec_pulse
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          at_last;

  assign at_last   = (pre_q == LAST);
  assign sec_pulse = adv && at_last && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else if (adv)     pre_q <= at_last ? '0 : pre_q + PW'(1);
  end

  AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(pre_q)); // R6
endmodule

// File: rtl/secs_count_core.sv
module secs_count_core
  import secs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_pulse,
  input  logic             count_on,
  input  logic             wr_hit,
  input  logic [1:0]       wr_idx,
  input  logic [7:0]       wr_byte,
  output logic [CNT_W-1:0] count_q
);
  logic do_step;
  assign do_step = sec_pulse && count_on;

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (wr_hit)  count_q <= put_byte(count_q, wr_idx, wr_byte);
    else if (do_step) count_q <= step_count(count_q);
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && count_on && !wr_hit) |=> (count_q == $past(count_q) + 32'd1)); // R1
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_on && !wr_hit) |=> $stable(count_q)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == 32'hFFFF_FFFF && sec_pulse && count_on && !wr_hit) |=> (count_q == 32'd0)); // R8
endmodule

// File: rtl/secs_regs.sv
module secs_regs
  import secs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              halt_in,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  count_q,
  output logic              halt_q,
  output logic              cnt_wr_hit,
  output logic [7:0]        rd_data
);
  logic [CNT_W-1:0] shadow_q;
  logic             snap_load;
  logic             ctrl_hit;
  logic [7:0]       rd_next;

  assign cnt_wr_hit = wr_en && !wr_addr[2];
  assign ctrl_hit   = wr_en && (wr_addr == CTRL_ADDR);
  assign snap_load  = rd_en && (rd_addr == '0);

  always_comb begin
    rd_next = 8'h00;
    if (rd_addr == '0)            rd_next = get_byte(count_q, 2'd0);
    else if (!rd_addr[2])         rd_next = get_byte(shadow_q, rd_addr[1:0]);
    else if (rd_addr == CTRL_ADDR) rd_next[HALT_BIT] = halt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q   <= 1'b0;
      shadow_q <= '0;
      rd_data  <= '0;
    end else begin
      if (ctrl_hit)  halt_q   <= halt_in;
      if (snap_load) shadow_q <= count_q;
      if (rd_en)     rd_data  <= rd_next;
    end
  end

  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_load |=> $stable(shadow_q)); // R3
  AST_CTRL_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_hit |=> $stable(halt_q)); // R10
endmodule

// File: rtl/secs_counter.sv
module secs_counter
  import secs_pkg::*;
#(
  parameter int unsigned PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       on_battery,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  logic             halt_q;
  logic             cnt_wr_hit;
  logic             osc_run;
  logic             pre_adv;
  logic             sec_pulse;
  logic [CNT_W-1:0] count_q;

  // In backup mode the halt bit also stops the time base.
  assign osc_run = !(on_battery && halt_q);
  assign pre_adv = tick_en && osc_run;

  secs_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .halt_in    (wr_data[HALT_BIT]),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .count_q    (count_q),
    .halt_q     (halt_q),
    .cnt_wr_hit (cnt_wr_hit),
    .rd_data    (rd_data)
  );

  secs_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (pre_adv),
    .restart   (cnt_wr_hit),
    .sec_pulse (sec_pulse)
  );

  secs_count_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .count_on  (!halt_q),
    .wr_hit    (cnt_wr_hit),
    .wr_idx    (wr_addr[1:0]),
    .wr_byte   (wr_data),
    .count_q   (count_q)
  );

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_hit |=> !sec_pulse); // R4
  AST_BACKUP_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && halt_q) |-> !sec_pulse); // R6
endmodule

// File: tb/secs_counter_bench.sv
module secs_counter_bench;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       on_battery = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  secs_counter #(.PRESCALE_DIV(DIV)) u_secs_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .on_battery(on_battery),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference model built from the requirements.
  logic [31:0] m_cnt = '0;
  logic [31:0] m_shadow = '0;
  int          m_pre = 0;
  logic        m_halt = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_pre = 0; m_halt = 1'b0;
    end else begin
      if (wr_en && !wr_addr[2]) begin
        m_cnt[wr_addr[1:0]*8 +: 8] = wr_data;
        m_pre = 0;
      end else if (tick_en && !(on_battery && m_halt)) begin
        if (m_pre == DIV - 1) begin
          m_pre = 0;
          if (!m_halt) m_cnt = m_cnt + 1;
        end else m_pre = m_pre + 1;
      end
      if (wr_en && wr_addr == 3'd4) m_halt = wr_data[7];
    end
  end

  // Tick pattern generator: 0 off, 1 every cycle, 2 one in three.
  int tick_mode = 0;
  int tick_ph = 0;
  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % 3;
    case (tick_mode)
      1:       tick_en <= 1'b1;
      2:       tick_en <= (tick_ph == 0);
      default: tick_en <= 1'b0;
    endcase
  end

  // Scoreboard.
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_fire = 1'b0;

  always @(posedge clk) rd_fire <= rd_en && rst_n;

  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rd_data !== e) begin
        n_bad++;
        $display("FAIL %s: rd_data=%02h expected=%02h", t, rd_data, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    case (a)
      3'd0: begin e = m_cnt[7:0]; m_shadow = m_cnt; end
      3'd1, 3'd2, 3'd3: e = m_shadow[a[1:0]*8 +: 8];
      3'd4: e = {m_halt, 7'b0};
      default: e = 8'h00;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int i = 0; i < 4; i++) rd(3'(i), tag);
  endtask

  task automatic summary();
    idle(3);
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    // R9 reset state
    rd(3'd4, "R9"); rd_all("R9");
    rd(3'd5, "R10");
    // R1 R2 continuous ticks
    tick_mode = 1; idle(3 * DIV + 2); rd_all("R1");
    rd(3'd0, "R2");
    // R1 sparse ticks
    tick_mode = 2; idle(50); rd_all("R1");
    tick_mode = 0; idle(20); rd_all("R1");
    // R5 halt on main power
    tick_mode = 1;
    wr(3'd4, 8'hFF); rd(3'd4, "R5");
    idle(2 * DIV + 3); rd_all("R5");
    wr(3'd4, 8'h00); idle(3); rd_all("R5");
    // R6 halt in backup mode
    on_battery = 1'b1; idle(3);
    wr(3'd4, 8'h80); idle(3 * DIV + 1); rd_all("R6");
    wr(3'd4, 8'h00); idle(4); rd_all("R6");
    // R7 backup, not halted
    idle(2 * DIV + 1); rd_all("R7");
    on_battery = 1'b0;
    // R4 byte writes and R8 wrap
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    rd_all("R4");
    idle(2 * DIV - 2); rd_all("R8");
    idle(DIV); rd_all("R8");
    // R4 prescaler restart in mid-second
    idle(5); wr(3'd1, 8'h12);
    idle(DIV - 3); rd(3'd0, "R4");
    idle(1); rd_all("R4");
    // R3 snapshot across a carry into byte 1
    wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'hFF);
    idle(DIV - 1);
    rd(3'd0, "R3"); rd(3'd1, "R3"); rd(3'd2, "R3"); rd(3'd3, "R3");
    rd(3'd0, "R3"); rd(3'd1, "R3");
    // R10 unmapped addresses
    wr(3'd5, 8'hFF); wr(3'd6, 8'hAA); wr(3'd7, 8'h80);
    rd(3'd4, "R10"); rd_all("R10");
    rd(3'd6, "R10"); rd(3'd7, "R10");
    tick_mode = 0;
    done = 1;
    summary();
  end
endmodule